// File: doc/BRIEF.md
# Single-Cycle 32-Bit Load/Store Core

This block is a small processor that completes one instruction on every rising clock edge. Instructions are fixed 32-bit words kept in an internal word-addressed instruction store, which is filled through a write port while the core is held in reset. The supported work covers:

- register-to-register arithmetic and logic, and the two logical shifts;
- immediate arithmetic and logic;
- whole-word loads and stores to an internal byte-addressed data store;
- equal and not-equal conditional branches, and an absolute jump.

The core has a 32-entry register file with two operand read ports, a single write port and a third read port used for debug. Register 0 always holds zero. The data store places the most significant byte of a word at the lowest address. A debug port shows the program counter and any one register, so that a bench can compare the architectural state against its own model after every instruction.

Top module: `mcore_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC is cleared to 0 and every register and data-store byte is cleared to zero. The first instruction runs at the first rising edge with `rst_n` high.
- R2: Each edge fetches the word at index (PC >> 2) modulo IMEM_WORDS. Word i is written by `imem_we`/`imem_waddr`/`imem_wdata`. The fields are op [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0], imm [15:0] and target [25:0]. A non-control instruction advances the PC by 4, and the PC stays word aligned.
- R3: With op 0, funct 32 gives add, 34 sub, 36 and, 37 or and 39 nor. Each reads rs and rt and writes rd, and arithmetic wraps modulo 2^32.
- R4: With op 0, funct 0 shifts rt left by shamt and funct 2 shifts rt right by shamt with zero fill. Both write rd, and the rs field has no effect.
- R5: Op 8 (addi) adds rs to the sign-extended imm. Op 12 (andi) and op 13 (ori) combine rs with the zero-extended imm. All three write rt.
- R6: Register 0 reads as zero on every port, and writes addressed to it are discarded.
- R7: Op 35 (load) writes rt, and op 43 (store) writes rt to memory, at address rs + sign-extended imm. The four bytes at addr, addr+1, addr+2 and addr+3 (each modulo DMEM_BYTES, any alignment) form the word, with the most significant byte at addr. A store writes no register.
- R8: Op 4 branches when rs equals rt and op 5 when they differ. The target is PC+4 + (sign-extended imm << 2); otherwise the PC becomes PC+4.
- R9: Op 2 jumps to {PC+4 [31:28], target, 2'b00}.
- R10: Any other opcode, or op 0 with any other funct, changes no register and no memory, and advances the PC by 4.
- R11: `dbg_pc` shows the PC of the next instruction. `dbg_rdata` shows, combinationally, the register selected by `dbg_raddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_we | input | 1 | Instruction store write enable |
| imem_waddr | input | IMEM_AW | Instruction store word index |
| imem_wdata | input | 32 | Instruction word to store |
| dbg_raddr | input | 5 | Register selected for debug read |
| dbg_pc | output | 32 | Current program counter |
| dbg_rdata | output | 32 | Value of the selected register |

## Verification
Every architectural effect of an instruction (register write, store and PC update) takes place on the single rising edge that executes it. The effect is therefore visible at the debug port half a period later, with no further latency. The bench advances its reference model once per rising edge and compares the PC and the register just written at the following falling edge. It reads registers by moving `dbg_raddr` in small steps within that low half period. The reset state is checked at the falling edge after a reset edge, and a full register sweep closes each program.

// File: rtl/mcore_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings and control bundle for the single-cycle core.
// Assumes the fixed 32-bit instruction layouts; opcode and funct values are
// architectural and must not be renumbered.
package mcore_pkg;

    localparam int XLEN    = 32;
    localparam int REG_AW  = 5;

    // Primary opcodes (instr[31:26])
    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_JUMP  = 6'd2;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_BNE   = 6'd5;
    localparam logic [5:0] OPC_ADDI  = 6'd8;
    localparam logic [5:0] OPC_ANDI  = 6'd12;
    localparam logic [5:0] OPC_ORI   = 6'd13;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    // Function codes for the register layout (instr[5:0])
    localparam logic [5:0] FN_SLL = 6'd0;
    localparam logic [5:0] FN_SRL = 6'd2;
    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_NOR = 6'd39;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_NOR,
        ALU_SLL,
        ALU_SRL
    } alu_op_e;

    typedef struct packed {
        logic              rf_we;
        logic [REG_AW-1:0] rf_waddr;
        alu_op_e           alu_op;
        logic              b_is_imm;
        logic              mem_we;
        logic              wb_mem;
        logic              is_beq;
        logic              is_bne;
        logic              is_jump;
    } ctrl_t;

endpackage

// File: rtl/mcore_decode.sv
`timescale 1ns/1ps
// Module: mcore_decode
// Splits an instruction word into its fields, builds the control bundle and
// extends the 16-bit constant. Unknown opcodes/functs yield an all-idle bundle
// (no writes, sequential PC). Assumes the fixed R/I/J field positions.
module mcore_decode
    import mcore_pkg::*;
(
    input  logic [XLEN-1:0]   instr,
    output ctrl_t             ctrl,
    output logic [REG_AW-1:0] rs,
    output logic [REG_AW-1:0] rt,
    output logic [4:0]        shamt,
    output logic [XLEN-1:0]   imm_ext,
    output logic [25:0]       jaddr
);

    logic [5:0]        opcode;
    logic [5:0]        funct;
    logic [REG_AW-1:0] rd;
    logic [15:0]       imm16;
    logic              imm_zext;

    assign opcode = instr[31:26];
    assign rs     = instr[25:21];
    assign rt     = instr[20:16];
    assign rd     = instr[15:11];
    assign shamt  = instr[10:6];
    assign funct  = instr[5:0];
    assign imm16  = instr[15:0];
    assign jaddr  = instr[25:0];

    // Control generation from opcode and funct
    always_comb begin
        ctrl        = '0;
        ctrl.alu_op = ALU_ADD;
        imm_zext    = 1'b0;
        case (opcode)
            OPC_RTYPE: begin
                ctrl.rf_waddr = rd;
                case (funct)
                    FN_ADD: begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_ADD; end
                    FN_SUB: begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_SUB; end
                    FN_AND: begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_AND; end
                    FN_OR:  begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_OR;  end
                    FN_NOR: begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_NOR; end
                    FN_SLL: begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_SLL; end
                    FN_SRL: begin ctrl.rf_we = 1'b1; ctrl.alu_op = ALU_SRL; end
                    default: ctrl.rf_we = 1'b0;
                endcase
            end
            OPC_ADDI: begin
                ctrl.rf_we    = 1'b1;
                ctrl.rf_waddr = rt;
                ctrl.b_is_imm = 1'b1;
                ctrl.alu_op   = ALU_ADD;
            end
            OPC_ANDI: begin
                ctrl.rf_we    = 1'b1;
                ctrl.rf_waddr = rt;
                ctrl.b_is_imm = 1'b1;
                ctrl.alu_op   = ALU_AND;
                imm_zext      = 1'b1;
            end
            OPC_ORI: begin
                ctrl.rf_we    = 1'b1;
                ctrl.rf_waddr = rt;
                ctrl.b_is_imm = 1'b1;
                ctrl.alu_op   = ALU_OR;
                imm_zext      = 1'b1;
            end
            OPC_LOAD: begin
                ctrl.rf_we    = 1'b1;
                ctrl.rf_waddr = rt;
                ctrl.b_is_imm = 1'b1;
                ctrl.wb_mem   = 1'b1;
            end
            OPC_STORE: begin
                ctrl.mem_we   = 1'b1;
                ctrl.b_is_imm = 1'b1;
            end
            OPC_BEQ:  ctrl.is_beq  = 1'b1;
            OPC_BNE:  ctrl.is_bne  = 1'b1;
            OPC_JUMP: ctrl.is_jump = 1'b1;
            default:  ctrl.rf_we   = 1'b0;
        endcase
    end

    // Constant extension: zero fill for logic immediates, sign fill otherwise
    always_comb begin
        if (imm_zext) imm_ext = {16'h0000, imm16};
        else          imm_ext = {{16{imm16[15]}}, imm16};
    end

endmodule

// File: rtl/mcore_alu.sv
`timescale 1ns/1ps
// Module: mcore_alu
// Combinational arithmetic/logic/shift unit. Shifts operate on operand b
// (the rt value) by shamt; arithmetic wraps, no overflow detection.
// Also reports a == b for branch resolution.
module mcore_alu
    import mcore_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [4:0]      shamt,
    output logic [XLEN-1:0] y,
    output logic            eq
);

    // Operation select
    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_NOR: y = ~(a | b);
            ALU_SLL: y = b << shamt;
            ALU_SRL: y = b >> shamt;
            default: y = '0;
        endcase
    end

    assign eq = (a == b);

endmodule

// File: rtl/mcore_regfile.sv
`timescale 1ns/1ps
// Module: mcore_regfile
// 2^AW x W register file, NREAD combinational read ports, one synchronous
// write port. Entry 0 is never written and always reads zero. Synchronous
// active-low reset clears all entries.
module mcore_regfile #(
    parameter int W     = 32,
    parameter int AW    = 5,
    parameter int NREAD = 3,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr [NREAD],
    output logic [W-1:0]  rdata [NREAD],
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata
);

    logic [W-1:0] regs [DEPTH];

    // Write port with reset clear; entry 0 is discarded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    // One read mux per port, entry 0 forced to zero
    for (genvar p = 0; p < NREAD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
    end

endmodule

// File: rtl/mcore_dmem.sv
`timescale 1ns/1ps
// Module: mcore_dmem
// Byte-addressed data store, BYTES deep. A word access touches four
// consecutive bytes (address wraps modulo BYTES, any alignment), most
// significant byte at the lowest address. Combinational read, synchronous
// write, synchronous active-low reset to zero.
module mcore_dmem #(
    parameter int BYTES = 256,
    parameter int LANES = 4,
    localparam int AW = $clog2(BYTES),
    localparam int W  = 8 * LANES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [7:0]    mem [BYTES];
    logic [AW-1:0] lane_idx [LANES];

    // Per-lane byte index and read data, lane 0 is the most significant byte
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_idx[k] = addr + AW'(k);
        assign rdata[W-1-8*k -: 8] = mem[lane_idx[k]];
    end

    // Byte array update: clear on reset, write all lanes on store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BYTES; i++) mem[i] <= 8'h00;
        end else if (we) begin
            for (int k = 0; k < LANES; k++) mem[lane_idx[k]] <= wdata[W-1-8*k -: 8];
        end
    end

endmodule

// File: rtl/mcore_top.sv
`timescale 1ns/1ps
// Module: mcore_top
// Single-cycle core: fetch from the internal instruction store, decode,
// register read, ALU, data store access, write-back and next-PC selection all
// complete within one clock. The instruction store is loaded through the
// imem_* port (normally while rst_n is low). Debug port exposes PC and one
// register. Assumes IMEM_WORDS and DMEM_BYTES are powers of two.
module mcore_top
    import mcore_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_BYTES = 256,
    localparam int IMEM_AW = $clog2(IMEM_WORDS),
    localparam int DMEM_AW = $clog2(DMEM_BYTES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               imem_we,
    input  logic [IMEM_AW-1:0] imem_waddr,
    input  logic [XLEN-1:0]    imem_wdata,
    input  logic [REG_AW-1:0]  dbg_raddr,
    output logic [XLEN-1:0]    dbg_pc,
    output logic [XLEN-1:0]    dbg_rdata
);

    logic [XLEN-1:0]   imem [IMEM_WORDS];
    logic [XLEN-1:0]   pc_q, pc_next, pc_plus4;
    logic [XLEN-1:0]   instr;
    ctrl_t             ctrl;
    logic [REG_AW-1:0] rs, rt;
    logic [4:0]        shamt;
    logic [XLEN-1:0]   imm_ext;
    logic [25:0]       jaddr;
    logic [REG_AW-1:0] rf_ra [3];
    logic [XLEN-1:0]   rf_rd [3];
    logic [XLEN-1:0]   rs_val, rt_val;
    logic [XLEN-1:0]   alu_b, alu_y, ld_data, wb_data;
    logic              alu_eq;
    logic [XLEN-1:0]   br_target, j_target;

    // Instruction store write port
    always_ff @(posedge clk) begin
        if (imem_we) imem[imem_waddr] <= imem_wdata;
    end

    // Fetch by word index of the PC
    assign instr = imem[pc_q[IMEM_AW+1:2]];

    mcore_decode u_dec (
        .instr   (instr),
        .ctrl    (ctrl),
        .rs      (rs),
        .rt      (rt),
        .shamt   (shamt),
        .imm_ext (imm_ext),
        .jaddr   (jaddr)
    );

    assign rf_ra[0] = rs;
    assign rf_ra[1] = rt;
    assign rf_ra[2] = dbg_raddr;
    assign rs_val   = rf_rd[0];
    assign rt_val   = rf_rd[1];

    mcore_regfile #(.W(XLEN), .AW(REG_AW), .NREAD(3)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (rf_ra),
        .rdata (rf_rd),
        .we    (ctrl.rf_we),
        .waddr (ctrl.rf_waddr),
        .wdata (wb_data)
    );

    assign alu_b = ctrl.b_is_imm ? imm_ext : rt_val;

    mcore_alu u_alu (
        .op    (ctrl.alu_op),
        .a     (rs_val),
        .b     (alu_b),
        .shamt (shamt),
        .y     (alu_y),
        .eq    (alu_eq)
    );

    mcore_dmem #(.BYTES(DMEM_BYTES), .LANES(XLEN / 8)) u_dmem (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (alu_y[DMEM_AW-1:0]),
        .we    (ctrl.mem_we),
        .wdata (rt_val),
        .rdata (ld_data)
    );

    assign wb_data = ctrl.wb_mem ? ld_data : alu_y;

    // Control-flow targets
    assign pc_plus4  = pc_q + 32'd4;
    assign br_target = pc_plus4 + {imm_ext[29:0], 2'b00};
    assign j_target  = {pc_plus4[31:28], jaddr, 2'b00};

    // Next-PC selection
    always_comb begin
        pc_next = pc_plus4;
        if (ctrl.is_jump)                    pc_next = j_target;
        else if (ctrl.is_beq &&  alu_eq)     pc_next = br_target;
        else if (ctrl.is_bne && !alu_eq)     pc_next = br_target;
    end

    // Program counter register
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_next;
    end

    assign dbg_pc    = pc_q;
    assign dbg_rdata = rf_rd[2];

endmodule

// File: rtl/mcore_checker.sv
`timescale 1ns/1ps
// Module: mcore_checker
// Temporal checks on the core's PC sequencing, register 0 and store path.
// Attached to every mcore_top instance by the bind below.
module mcore_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc,
    input logic [31:0] br_target,
    input logic [25:0] jaddr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        is_beq,
    input logic        is_bne,
    input logic        is_jump,
    input logic        mem_we,
    input logic        rf_we,
    input logic [4:0]  dbg_raddr,
    input logic [31:0] dbg_rdata
);

    assert_pc_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> pc == 32'd0);

    assert_pc_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc[1:0] == 2'b00);

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_beq && !is_bne && !is_jump) |=> pc == $past(pc) + 32'd4);

    assert_r0_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_raddr == 5'd0 |-> dbg_rdata == 32'd0);

    assert_store_nowb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !rf_we);

    assert_beq_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_beq && rs_val == rt_val) |=> pc == $past(br_target));

    assert_bne_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_bne && rs_val != rt_val) |=> pc == $past(br_target));

    assert_jump_R9: assert property (@(posedge clk) disable iff (!rst_n)
        is_jump |=> pc[27:2] == $past(jaddr));

endmodule

bind mcore_top mcore_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc        (pc_q),
    .br_target (br_target),
    .jaddr     (jaddr),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .is_beq    (ctrl.is_beq),
    .is_bne    (ctrl.is_bne),
    .is_jump   (ctrl.is_jump),
    .mem_we    (ctrl.mem_we),
    .rf_we     (ctrl.rf_we),
    .dbg_raddr (dbg_raddr),
    .dbg_rdata (dbg_rdata)
);

// File: tb/sim_mcore_top.sv
`timescale 1ns/1ps
// Bench: reference model of the core driven by directed and seeded random
// programs; compares PC and registers through the debug port.
module sim_mcore_top;

    localparam int NW = 64;
    localparam int NB = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_we = 1'b0;
    logic [5:0]  imem_waddr = '0;
    logic [31:0] imem_wdata = '0;
    logic [4:0]  dbg_raddr = '0;
    logic [31:0] dbg_pc, dbg_rdata;

    int nchecks = 0;
    int nerrors = 0;

    logic [31:0] prog  [NW];
    logic [31:0] mregs [32];
    logic [7:0]  mmem  [NB];
    logic [31:0] mpc;
    logic [4:0]  last_wa;

    always #2.5 clk = ~clk;

    mcore_top #(.IMEM_WORDS(NW), .DMEM_BYTES(NB)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_we    (imem_we),
        .imem_waddr (imem_waddr),
        .imem_wdata (imem_wdata),
        .dbg_raddr  (dbg_raddr),
        .dbg_pc     (dbg_pc),
        .dbg_rdata  (dbg_rdata)
    );

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [4:0] rd,
                                          input logic [4:0] sh);
        return {6'd0, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_j(input logic [25:0] a);
        return {6'd2, a};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerrors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic read_reg(input logic [4:0] idx, output logic [31:0] val);
        dbg_raddr = idx;
        #0.05;
        val = dbg_rdata;
    endtask

    // Reference model: execute one instruction (requirements R2-R10)
    task automatic model_step();
        logic [31:0] ins, a, b, sx, zx, npc, wd, ad;
        logic [5:0]  op, fn;
        logic [4:0]  rs, rt, rd, sh, wa;
        logic        we;
        ins = prog[mpc[7:2]];
        op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
        sh = ins[10:6];  fn = ins[5:0];
        sx = {{16{ins[15]}}, ins[15:0]};
        zx = {16'h0, ins[15:0]};
        a = mregs[rs]; b = mregs[rt];
        npc = mpc + 32'd4; we = 1'b0; wa = 5'd0; wd = '0;
        ad = a + sx;
        case (op)
            6'd0: begin
                wa = rd; we = 1'b1;
                case (fn)
                    6'd32: wd = a + b;
                    6'd34: wd = a - b;
                    6'd36: wd = a & b;
                    6'd37: wd = a | b;
                    6'd39: wd = ~(a | b);
                    6'd0:  wd = b << sh;
                    6'd2:  wd = b >> sh;
                    default: we = 1'b0;
                endcase
            end
            6'd8:  begin we = 1'b1; wa = rt; wd = a + sx; end
            6'd12: begin we = 1'b1; wa = rt; wd = a & zx; end
            6'd13: begin we = 1'b1; wa = rt; wd = a | zx; end
            6'd35: begin
                we = 1'b1; wa = rt;
                wd = {mmem[ad[7:0]], mmem[8'(ad[7:0] + 8'd1)],
                      mmem[8'(ad[7:0] + 8'd2)], mmem[8'(ad[7:0] + 8'd3)]};
            end
            6'd43: begin
                mmem[ad[7:0]] = b[31:24];
                mmem[8'(ad[7:0] + 8'd1)] = b[23:16];
                mmem[8'(ad[7:0] + 8'd2)] = b[15:8];
                mmem[8'(ad[7:0] + 8'd3)] = b[7:0];
            end
            6'd4: if (a == b) npc = mpc + 32'd4 + {sx[29:0], 2'b00};
            6'd5: if (a != b) npc = mpc + 32'd4 + {sx[29:0], 2'b00};
            6'd2: npc = {npc[31:28], ins[25:0], 2'b00};
            default: we = 1'b0;
        endcase
        if (we && wa != 5'd0) mregs[wa] = wd;
        last_wa = we ? wa : 5'd0;
        mpc = npc;
    endtask

    // Reset, load the program, and check the reset state (R1)
    task automatic load_and_reset();
        logic [31:0] v;
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < NW; i++) begin
            imem_we = 1'b1; imem_waddr = 6'(i); imem_wdata = prog[i];
            @(negedge clk);
        end
        imem_we = 1'b0;
        for (int i = 0; i < 32; i++) mregs[i] = '0;
        for (int i = 0; i < NB; i++) mmem[i] = '0;
        mpc = '0; last_wa = '0;
        check("R1 pc after reset", dbg_pc, 32'd0);
        read_reg(5'd1, v);  check("R1 r1 after reset", v, 32'd0);
        read_reg(5'd4, v);  check("R1 r4 after reset", v, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Run n cycles against the model, checking PC and the written register (R11)
    task automatic run(input int n);
        logic [31:0] v;
        for (int c = 0; c < n; c++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            check("R2/R8/R9 pc", dbg_pc, mpc);
            read_reg(last_wa, v);
            check("R3-R7/R11 dest reg", v, mregs[last_wa]);
        end
    endtask

    task automatic sweep(input string tag);
        logic [31:0] v;
        for (int r = 0; r < 32; r++) begin
            read_reg(5'(r), v);
            check(tag, v, mregs[r]);
        end
    endtask

    function automatic logic [31:0] rand_instr();
        logic [4:0]  rs, rt, rd;
        logic [15:0] imm;
        int k;
        rs = 5'($urandom_range(0, 7));
        rt = 5'($urandom_range(0, 7));
        rd = 5'($urandom_range(0, 7));
        imm = 16'($urandom);
        k = $urandom_range(0, 13);
        case (k)
            0:  return enc_r(6'd32, rs, rt, rd, 5'd0);
            1:  return enc_r(6'd34, rs, rt, rd, 5'd0);
            2:  return enc_r(6'd36, rs, rt, rd, 5'd0);
            3:  return enc_r(6'd37, rs, rt, rd, 5'd0);
            4:  return enc_r(6'd39, rs, rt, rd, 5'd0);
            5:  return enc_r(($urandom_range(0, 1) != 0) ? 6'd2 : 6'd0,
                             5'($urandom), rt, rd, 5'($urandom));
            6:  return enc_i(6'd8, rs, rt, imm);
            7:  return enc_i(($urandom_range(0, 1) != 0) ? 6'd13 : 6'd12, rs, rt, imm);
            8:  return enc_i(6'd35, rs, rt, imm);
            9:  return enc_i(6'd43, rs, rt, imm);
            10: return enc_i(($urandom_range(0, 1) != 0) ? 6'd5 : 6'd4, rs, rt,
                             16'($signed($urandom_range(0, 12)) - 6));
            11: return enc_j(26'($urandom_range(0, NW - 1)));
            12: return enc_i(6'd8, rs, rt, 16'($urandom_range(0, 40)));
            default: return ($urandom_range(0, 1) != 0) ? enc_i(6'd63, rs, rt, imm)
                                                        : enc_r(6'd5, rs, rt, rd, 5'd0);
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        nchecks++; nerrors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", nchecks, nerrors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7321));

        // Directed program
        for (int i = 0; i < NW; i++) prog[i] = 32'h0;
        prog[0]  = enc_i(6'd8,  5'd0, 5'd1, 16'hFFFE);          // addi r1 = -2
        prog[1]  = enc_i(6'd13, 5'd0, 5'd2, 16'h8001);          // ori zero-ext
        prog[2]  = enc_i(6'd12, 5'd1, 5'd3, 16'hFFFF);          // andi zero-ext
        prog[3]  = enc_r(6'd32, 5'd1, 5'd2, 5'd4, 5'd0);        // add wraps
        prog[4]  = enc_r(6'd34, 5'd2, 5'd1, 5'd5, 5'd0);        // sub
        prog[5]  = enc_r(6'd39, 5'd1, 5'd0, 5'd6, 5'd0);        // nor
        prog[6]  = enc_r(6'd0,  5'd31, 5'd2, 5'd7, 5'd4);       // sll, rs ignored
        prog[7]  = enc_r(6'd2,  5'd0, 5'd1, 5'd8, 5'd28);       // srl zero fill
        prog[8]  = enc_i(6'd8,  5'd0, 5'd0, 16'd5);             // write r0
        prog[9]  = enc_i(6'd43, 5'd0, 5'd4, 16'd8);             // sw r4 -> 8
        prog[10] = enc_i(6'd43, 5'd0, 5'd5, 16'd12);            // sw r5 -> 12
        prog[11] = enc_i(6'd35, 5'd0, 5'd9, 16'd10);            // lw unaligned
        prog[12] = enc_i(6'd35, 5'd0, 5'd10, 16'd8);            // lw aligned
        prog[13] = enc_i(6'd4,  5'd10, 5'd4, 16'd1);            // beq taken
        prog[14] = enc_i(6'd8,  5'd0, 5'd11, 16'd1);            // skipped
        prog[15] = enc_i(6'd5,  5'd10, 5'd4, 16'd5);            // bne not taken
        prog[16] = enc_i(6'd8,  5'd0, 5'd12, 16'd7);
        prog[17] = enc_j(26'd19);                               // jump
        prog[18] = enc_i(6'd8,  5'd0, 5'd13, 16'd1);            // skipped
        prog[19] = enc_i(6'd63, 5'd1, 5'd14, 16'h1234);         // unknown opcode
        prog[20] = enc_r(6'd5,  5'd1, 5'd2, 5'd15, 5'd0);       // unknown funct
        prog[21] = enc_i(6'd5,  5'd12, 5'd0, 16'hFFFF);         // bne to itself

        load_and_reset();
        run(30);
        check("R8/R10 spin pc", dbg_pc, 32'd84);
        read_reg(5'd1, v);  check("R5 addi sign-ext", v, 32'hFFFF_FFFE);
        read_reg(5'd2, v);  check("R5 ori zero-ext", v, 32'h0000_8001);
        read_reg(5'd3, v);  check("R5 andi zero-ext", v, 32'h0000_FFFE);
        read_reg(5'd4, v);  check("R3 add wrap", v, 32'h0000_7FFF);
        read_reg(5'd5, v);  check("R3 sub", v, 32'h0000_8003);
        read_reg(5'd6, v);  check("R3 nor", v, 32'h0000_0001);
        read_reg(5'd7, v);  check("R4 sll", v, 32'h0008_0010);
        read_reg(5'd8, v);  check("R4 srl", v, 32'h0000_000F);
        read_reg(5'd0, v);  check("R6 r0 discard", v, 32'h0);
        read_reg(5'd9, v);  check("R7 big-endian unaligned", v, 32'h7FFF_0000);
        read_reg(5'd10, v); check("R7 load word", v, 32'h0000_7FFF);
        read_reg(5'd11, v); check("R8 beq skip", v, 32'h0);
        read_reg(5'd12, v); check("R8 bne fallthrough", v, 32'h7);
        read_reg(5'd13, v); check("R9 jump skip", v, 32'h0);
        read_reg(5'd14, v); check("R10 bad opcode", v, 32'h0);
        read_reg(5'd15, v); check("R10 bad funct", v, 32'h0);
        sweep("R11 directed sweep");

        // Seeded random programs
        for (int p = 0; p < 6; p++) begin
            for (int i = 0; i < NW; i++) prog[i] = rand_instr();
            load_and_reset();
            run(400);
            sweep("R11 random sweep");
        end

        $display("  CHECKS %0d ERRORS %0d", nchecks, nerrors);
        $finish;
    end

endmodule